// File: doc/BRIEF.md
# Event Interrupt and DMA Request Controller

This block collects event pulses from the transfer engine of a memory-mapped serial-bus controller. Each pulse sets a sticky bit in a 16-bit event status register. A mask register selects which events raise the single level-sensitive interrupt line. Two DMA request lines are driven from the receive-ready and transmit-ready events once DMA is switched on for that direction. When DMA is turned on for a direction, the interrupt enable for that direction is cleared in the same write, so the processor and the DMA engine never both service the same event.

A build-time revision parameter picks one of two ways of acknowledging events. Older revisions have a vector register. Reading it returns the 1-based number of the lowest pending enabled event and acknowledges that event in the same access. On these revisions the status register cannot be written. Newer revisions have no vector register. Instead, software writes 1s to the status register to clear a fixed subset of its bits. The enable register is 5 bits wide on older revisions and 6 bits wide on newer ones. A status read also shows the live bus-busy flag in bit 12.

Top module: `evt_irq_ctrl`

## Requirements
- R1: `irq` is high in the cycle after any cycle in which the status register AND the enable register is nonzero, and low in the cycle after it is zero.
- R2: A 1 on `ev_set[i]` sets status bit i at the next clock edge. If a clear of the same bit arrives in the same cycle (vector read or write-1-to-clear), the set wins.
- R3: `dma_rx_req` equals status bit 3 (receive ready) one cycle later, while DMA-config bit 15 is set. `dma_tx_req` equals status bit 4 (transmit ready) one cycle later, while DMA-config bit 7 is set. Each request is low while its config bit is clear.
- R4: A write to DMA config (`reg_sel`=3) stores only data bits 15 and 7 and reads back with all other bits 0. Writing bit 15 as 1 clears enable bit 3. Writing bit 7 as 1 clears enable bit 4.
- R5: On revisions below 0x34, a vector read (`reg_sel`=2) returns 0 when status AND enable is zero. Otherwise it returns the lowest set bit position of status AND enable plus 1, and clears that status bit at the same clock edge.
- R6: Below revision 0x34, writes to status have no effect. At 0x34 or above, a status write (`reg_sel`=0) clears each status bit among 0, 1, 2 and 5 that is written as 1, leaves every other bit unchanged, and a vector read returns 0 and clears nothing.
- R7: A write to enable (`reg_sel`=1) keeps data bits 4..0 below revision 0x34 and bits 5..0 otherwise. The remaining bits read as 0.
- R8: A status read returns the stored status with `bus_busy` ORed into bit 12.
- R9: `rd_data` shows the selected register in the same cycle as `reg_rd` (0 status, 1 enable, 2 vector, 3 DMA config) and is 0 while `reg_rd` is low. After reset every register and output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_set | input | 16 | One-cycle event set pulses from the transfer engine |
| bus_busy | input | 1 | Live bus-busy flag shown in status bit 12 |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 status, 1 enable, 2 vector, 3 DMA config |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, combinational during `reg_rd` |
| irq | output | 1 | Registered level interrupt |
| dma_rx_req | output | 1 | Registered receive DMA request |
| dma_tx_req | output | 1 | Registered transmit DMA request |

## Verification
Read data is combinational, so the bench checks it 1 ns after it drives the read strobe, inside the same cycle. The status clear caused by that read shows up only at the following edge. Status, enable and DMA config change at the edge where a strobe or pulse is sampled. `irq` and both DMA requests follow one further edge later. The bench therefore compares them at each falling edge against a model whose outputs come from the state before the most recent rising edge. Two instances, one on each side of the revision threshold, get the same stimulus, and each is checked against its own model every cycle.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
   typedef enum logic [1:0] {
      SEL_STAT = 2'd0,
      SEL_EN   = 2'd1,
      SEL_VEC  = 2'd2,
      SEL_DMA  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/evt_lsb_encoder.sv
module evt_lsb_encoder #(
   parameter int W     = 16,
   parameter int IDX_W = $clog2(W + 1)
) (
   input  logic [W-1:0]     vec,
   output logic [W-1:0]     onehot,
   output logic [IDX_W-1:0] idx
);
   logic [W:0] below;
   assign below[0] = 1'b0;

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign onehot[i]   = vec[i] & ~below[i];
      assign below[i+1]  = below[i] | vec[i];
   end

   always_comb begin
      idx = '0;
      for (int i = 0; i < W; i++)
         if (onehot[i]) idx = idx | IDX_W'(i + 1);
   end
endmodule

// File: rtl/evt_status_reg.sv
module evt_status_reg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic [W-1:0] clr,
   output logic [W-1:0] stat
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat <= '0;
      else        stat <= (stat & ~clr) | set;
   end

   // R2: a pulsed event is always present after the edge, even against a clear
   p_set_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (set != '0) |=> ((stat & $past(set)) == $past(set)));
endmodule

// File: rtl/evt_out_stage.sv
module evt_out_stage #(
   parameter int W      = 16,
   parameter int RX_BIT = 3,
   parameter int TX_BIT = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] stat,
   input  logic [W-1:0] en,
   input  logic         rx_on,
   input  logic         tx_on,
   output logic         irq,
   output logic         rx_req,
   output logic         tx_req
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq    <= 1'b0;
         rx_req <= 1'b0;
         tx_req <= 1'b0;
      end else begin
         irq    <= |(stat & en);
         rx_req <= rx_on & stat[RX_BIT];
         tx_req <= tx_on & stat[TX_BIT];
      end
   end

   // R3: a request never asserts while its direction is switched off
   p_rx_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_on |=> !rx_req);
   p_tx_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_on |=> !tx_req);
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
   import evt_irq_pkg::*;
#(
   parameter int          REG_W      = 16,
   parameter logic [7:0]  REVISION   = 8'h20,
   parameter logic [7:0]  VEC_REV    = 8'h34,
   parameter int          BUSY_BIT   = 12,
   parameter int          RX_BIT     = 3,
   parameter int          TX_BIT     = 4,
   parameter int          RX_DMA_BIT = 15,
   parameter int          TX_DMA_BIT = 7,
   parameter logic [15:0] W1C_MASK   = 16'h0027
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] ev_set,
   input  logic             bus_busy,
   input  logic             reg_rd,
   input  logic             reg_wr,
   input  logic [1:0]       reg_sel,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   output logic             irq,
   output logic             dma_rx_req,
   output logic             dma_tx_req
);
   localparam bit HAS_VEC = (REVISION < VEC_REV);
   localparam int EN_W    = HAS_VEC ? 5 : 6;
   localparam int IDX_W   = $clog2(REG_W + 1);

   if (REG_W < 16)         $error("REG_W must cover all event bits");
   if (EN_W <= TX_BIT)     $error("enable width must cover the transmit bit");
   if (BUSY_BIT >= REG_W)  $error("busy bit outside register");

   reg_sel_e sel;
   assign sel = reg_sel_e'(reg_sel);

   logic [REG_W-1:0] stat, clr, pend, onehot, w1c, vec_val;
   logic [IDX_W-1:0] vec_idx;
   logic [EN_W-1:0]  en_q;
   logic [REG_W-1:0] en_full;
   logic             rx_on, tx_on, vec_rd_en;
   logic             unused_bits;

   assign en_full = REG_W'(en_q);
   assign pend    = stat & en_full;

   evt_lsb_encoder #(.W(REG_W), .IDX_W(IDX_W)) u_enc (
      .vec(pend), .onehot(onehot), .idx(vec_idx));

   if (HAS_VEC) begin : g_vec
      assign vec_rd_en = reg_rd && (sel == SEL_VEC);
      assign w1c       = '0;
      assign vec_val   = REG_W'(vec_idx);

      // R6: status bits only ever fall through a vector read
      p_status_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !vec_rd_en |=> (($past(stat) & ~stat) == '0));
   end else begin : g_w1c
      assign vec_rd_en = 1'b0;
      assign w1c       = (reg_wr && sel == SEL_STAT) ? (wr_data & REG_W'(W1C_MASK)) : '0;
      assign vec_val   = '0;

      // R6: a status write lowers nothing outside the clearable set
      p_w1c_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_wr && sel == SEL_STAT) |=>
            ((($past(stat) & ~stat) & ~REG_W'(W1C_MASK)) == '0));
   end

   assign clr = w1c | (vec_rd_en ? onehot : '0);

   evt_status_reg #(.W(REG_W)) u_stat (
      .clk(clk), .rst_n(rst_n), .set(ev_set), .clr(clr), .stat(stat));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         rx_on <= 1'b0;
         tx_on <= 1'b0;
      end else if (reg_wr && sel == SEL_EN) begin
         en_q <= wr_data[EN_W-1:0];
      end else if (reg_wr && sel == SEL_DMA) begin
         rx_on <= wr_data[RX_DMA_BIT];
         tx_on <= wr_data[TX_DMA_BIT];
         if (wr_data[RX_DMA_BIT]) en_q[RX_BIT] <= 1'b0;
         if (wr_data[TX_DMA_BIT]) en_q[TX_BIT] <= 1'b0;
      end
   end

   always_comb begin
      rd_data = '0;
      if (reg_rd) begin
         unique case (sel)
            SEL_STAT: rd_data = stat | (REG_W'(bus_busy) << BUSY_BIT);
            SEL_EN:   rd_data = en_full;
            SEL_VEC:  rd_data = vec_val;
            SEL_DMA:  begin
               rd_data[RX_DMA_BIT] = rx_on;
               rd_data[TX_DMA_BIT] = tx_on;
            end
         endcase
      end
   end

   assign unused_bits = ^{wr_data, vec_idx};

   evt_out_stage #(.W(REG_W), .RX_BIT(RX_BIT), .TX_BIT(TX_BIT)) u_out (
      .clk(clk), .rst_n(rst_n), .stat(stat), .en(en_full),
      .rx_on(rx_on), .tx_on(tx_on),
      .irq(irq), .rx_req(dma_rx_req), .tx_req(dma_tx_req));

   // R1: the interrupt line tracks pending enabled events one edge later
   p_irq_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (pend != '0) |=> irq);

   // R4: enabling receive DMA removes the receive-ready interrupt enable
   p_dma_clears_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && sel == SEL_DMA && wr_data[RX_DMA_BIT]) |=> !en_q[RX_BIT]);

   // R5: the vector read acknowledges the event it reports
   p_vec_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_rd_en && pend != '0 && (ev_set & onehot) == '0) |=>
         ((stat & $past(onehot)) == '0));
endmodule

// File: tb/tb_evt_irq_ctrl.sv
module tb_evt_irq_ctrl;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] ev_set = '0;
   logic        bus_busy = 1'b0;
   logic        reg_rd = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_a, rd_b;
   logic        irq_a, irq_b, rx_a, rx_b, tx_a, tx_b;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   evt_irq_ctrl #(.REVISION(8'h20)) dut (
      .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .bus_busy(bus_busy),
      .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_sel(reg_sel), .wr_data(wr_data),
      .rd_data(rd_a), .irq(irq_a), .dma_rx_req(rx_a), .dma_tx_req(tx_a));

   evt_irq_ctrl #(.REVISION(8'h34)) dut_v2 (
      .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .bus_busy(bus_busy),
      .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_sel(reg_sel), .wr_data(wr_data),
      .rd_data(rd_b), .irq(irq_b), .dma_rx_req(rx_b), .dma_tx_req(tx_b));

   // reference model, index 0 = older revision, 1 = newer revision
   int m_stat[2], m_en[2], m_dma[2];
   int m_irq[2], m_rx[2], m_tx[2];

   function automatic int lowest_idx(int v);
      for (int i = 0; i < 16; i++)
         if (v[i]) return i + 1;
      return 0;
   endfunction

   function automatic int exp_rd(int k);
      int p;
      if (!reg_rd) return 0;                       // R9
      p = m_stat[k] & m_en[k];
      case (reg_sel)
         2'd0: return m_stat[k] | (int'(bus_busy) << 12);   // R8
         2'd1: return m_en[k];                              // R7
         2'd2: return (k == 0) ? lowest_idx(p) : 0;         // R5/R6
         default: return m_dma[k];                          // R4
      endcase
   endfunction

   always @(posedge clk) begin
      for (int k = 0; k < 2; k++) begin
         if (!rst_n) begin
            m_stat[k] = 0; m_en[k] = 0; m_dma[k] = 0;
            m_irq[k] = 0; m_rx[k] = 0; m_tx[k] = 0;
         end else begin
            int clr, p;
            p     = m_stat[k] & m_en[k];
            clr   = 0;
            m_irq[k] = (p != 0);
            m_rx[k]  = m_dma[k][15] & m_stat[k][3];
            m_tx[k]  = m_dma[k][7] & m_stat[k][4];
            if (k == 0 && reg_rd && reg_sel == 2'd2 && p != 0)
               clr = 1 << (lowest_idx(p) - 1);
            if (k == 1 && reg_wr && reg_sel == 2'd0)
               clr = int'(wr_data) & 32'h27;
            m_stat[k] = (m_stat[k] & ~clr) | int'(ev_set);
            if (reg_wr && reg_sel == 2'd1)
               m_en[k] = int'(wr_data) & ((k == 0) ? 32'h1f : 32'h3f);
            if (reg_wr && reg_sel == 2'd3) begin
               m_dma[k] = int'(wr_data) & 32'h8080;
               if (wr_data[15]) m_en[k] = m_en[k] & ~32'h8;
               if (wr_data[7])  m_en[k] = m_en[k] & ~32'h10;
            end
         end
      end
   end

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic step(logic [1:0] sel, logic rd, logic wr, logic [15:0] d, logic [15:0] ev);
      @(negedge clk);
      check("R1 irq old-rev", int'(irq_a), m_irq[0]);
      check("R1 irq new-rev", int'(irq_b), m_irq[1]);
      check("R3 rx req old-rev", int'(rx_a), m_rx[0]);
      check("R3 rx req new-rev", int'(rx_b), m_rx[1]);
      check("R3 tx req old-rev", int'(tx_a), m_tx[0]);
      check("R3 tx req new-rev", int'(tx_b), m_tx[1]);
      reg_sel = sel; reg_rd = rd; reg_wr = wr; wr_data = d; ev_set = ev;
      #1;
      check("R9/R2/R4/R5/R6/R7/R8 read old-rev", int'(rd_a), exp_rd(0));
      check("R9/R2/R4/R5/R6/R7/R8 read new-rev", int'(rd_b), exp_rd(1));
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(2'd0, 1'b0, 1'b0, 16'h0, 16'h0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 50000) begin
         fails++;
         $display("FAIL watchdog all-requirements actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int lfsr = 32'h1d2c3b4a;
      for (int k = 0; k < 2; k++) begin
         m_stat[k] = 0; m_en[k] = 0; m_dma[k] = 0;
         m_irq[k] = 0; m_rx[k] = 0; m_tx[k] = 0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R9: reset state of every register
      for (int s = 0; s < 4; s++) step(2'(s), 1'b1, 1'b0, 16'h0, 16'h0);
      // R7: enable width
      step(2'd1, 1'b0, 1'b1, 16'hffff, 16'h0);
      step(2'd1, 1'b1, 1'b0, 16'h0, 16'h0);
      // R2 / R1: raise events 1 and 3
      step(2'd0, 1'b0, 1'b0, 16'h0, 16'h000a);
      idle(2);
      // R5: vector reads 2, then 4, then 0
      step(2'd2, 1'b1, 1'b0, 16'h0, 16'h0);
      step(2'd2, 1'b1, 1'b0, 16'h0, 16'h0);
      step(2'd2, 1'b1, 1'b0, 16'h0, 16'h0);
      idle(2);
      // R8: busy flag in status read
      bus_busy = 1'b1;
      step(2'd0, 1'b0, 1'b0, 16'h0, 16'h0827);
      step(2'd0, 1'b1, 1'b0, 16'h0, 16'h0);
      bus_busy = 1'b0;
      // R6: status write, clears only bits 0,1,2,5 on the newer revision
      step(2'd0, 1'b0, 1'b1, 16'hffff, 16'h0);
      step(2'd0, 1'b1, 1'b0, 16'h0, 16'h0);
      // R6: newer revision vector read returns 0
      step(2'd2, 1'b1, 1'b0, 16'h0, 16'h0);
      // R2: set wins over same-cycle write clear and vector clear
      step(2'd0, 1'b0, 1'b1, 16'h0001, 16'h0001);
      step(2'd2, 1'b1, 1'b0, 16'h0, 16'h0001);
      step(2'd0, 1'b1, 1'b0, 16'h0, 16'h0);
      // R4 / R3: DMA enables, enable bits dropped, requests follow
      step(2'd1, 1'b0, 1'b1, 16'h001f, 16'h0);
      step(2'd3, 1'b0, 1'b1, 16'hffff, 16'h0018);
      step(2'd3, 1'b1, 1'b0, 16'h0, 16'h0);
      step(2'd1, 1'b1, 1'b0, 16'h0, 16'h0);
      idle(2);
      step(2'd3, 1'b0, 1'b1, 16'h0080, 16'h0);
      idle(2);
      step(2'd3, 1'b0, 1'b1, 16'h0000, 16'h0);
      idle(2);
      // mixed stimulus covering all requirements
      for (int i = 0; i < 400; i++) begin
         lfsr = (lfsr << 1) ^ ((lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]) ? 1 : 0);
         bus_busy = lfsr[9];
         step(2'(lfsr[3:2]), lfsr[4], lfsr[5] & lfsr[6],
              16'(lfsr[31:16]),
              lfsr[7] ? (16'(1) << lfsr[13:10]) : 16'h0);
      end
      idle(3);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule